// File: doc/BRIEF.md
# Machine-Check Error Logging Register Bank

This block records a hardware error for later inspection by software. When an error-event pulse arrives, it stores a status word, an error address, a word of miscellaneous detail and copies of a configurable number of core register values, all in the same clock edge. Software reaches the stored state through an indexed access port with a strobe, a write flag, an index, write data and combinational read data. Any access that is not allowed returns a one-cycle protection-fault pulse instead of completing.

A capability register tells software whether the core register snapshot bank exists and how many entries it has. The logging registers cannot be loaded from the port. Software can only clear them by writing zero. The miscellaneous-detail register can be configured out entirely, and then every access to it faults. Bit 59 of the status word carries the error source's own flag saying that the miscellaneous detail is meaningful. The bank stores that bit and does not interpret it.

Register indices: capability 0x179, status 0x401, address 0x402, miscellaneous 0x403, snapshots from 0x180 upward.

Top module: `mce_log_bank`

## Requirements
- R1: After reset, the status, address, miscellaneous and snapshot registers all read zero, and the capability register reads its configured value.
- R2: The capability register holds the snapshot count in bits 7:0 and a present flag in bit 8. Bit 8 is 1 exactly when the count is nonzero, and all other bits read zero. Reading it does not fault.
- R3: An error-event pulse while the status valid bit (bit 63) is clear loads every logging register on the same edge. Status becomes bit 63 = 1, bit 62 = 0 and bits 61:0 from the input. Address, miscellaneous detail and every snapshot are loaded from their inputs. The new values are readable in the cycle after the pulse.
- R4: An error-event pulse while bit 63 is set sets the overflow bit (bit 62) and leaves every other stored bit unchanged.
- R5: With narrow addressing, only bits 35:0 of the captured address are kept, and bits 63:36 read zero.
- R6: A write of all zeros to the status, address or miscellaneous register clears that register alone and does not fault.
- R7: A write with any bit set to the status, address or miscellaneous register faults and changes no state.
- R8: When the miscellaneous register is configured out, every read and every write to index 0x403 faults.
- R9: A read of index 0x180+k returns the core register k captured at the last logging event, for k below the count. An index at or above 0x180 plus the count faults.
- R10: Any write to the capability register or to a snapshot index faults.
- R11: The fault output is high only in a cycle where the access strobe is high with an illegal access, including any unmapped index. A faulting access returns zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_vld_i | input | 1 | Access strobe |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| acc_idx_i | input | 12 | Register index |
| acc_wdata_i | input | DATA_W | Write data |
| acc_rdata_o | output | DATA_W | Combinational read data |
| fault_o | output | 1 | Protection fault, same cycle as the strobe |
| err_evt_i | input | 1 | Error-event pulse |
| err_stat_i | input | DATA_W | Status to log |
| err_addr_i | input | DATA_W | Address to log |
| err_misc_i | input | DATA_W | Miscellaneous detail to log |
| core_regs_i | input | NUM_SNAP*DATA_W | Core register values, entry k in slice k |

## Verification
Read data and the fault flag are combinational from the strobe and the stored registers. The bench therefore drives an access just after a falling edge and samples both outputs 2 ns later, in the same cycle. A capture or a clearing write becomes visible one edge later. Each event pulse and each write is held across exactly one rising edge, and a separate read afterwards checks the result. A second instance, with the miscellaneous register and the snapshot bank configured out, shares the same stimulus so that the faulting configuration can be checked.

// File: rtl/mce_log_pkg.sv
package mce_log_pkg;
  localparam int unsigned IDX_W = 12;
  localparam logic [IDX_W-1:0] IDX_CAP       = 12'h179;
  localparam logic [IDX_W-1:0] IDX_SNAP_BASE = 12'h180;
  localparam logic [IDX_W-1:0] IDX_STAT      = 12'h401;
  localparam logic [IDX_W-1:0] IDX_ADDR      = 12'h402;
  localparam logic [IDX_W-1:0] IDX_MISC      = 12'h403;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CAP,
    SEL_STAT,
    SEL_ADDR,
    SEL_MISC,
    SEL_SNAP
  } reg_sel_e;
endpackage

// File: rtl/mce_acc_decode.sv
module mce_acc_decode
  import mce_log_pkg::*;
#(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned SNAP_CNT  = 4,
  parameter int unsigned OFS_W     = 2,
  parameter bit          MISC_IMPL = 1'b1
) (
  input  logic              acc_vld_i,
  input  logic              acc_wr_i,
  input  logic [IDX_W-1:0]  acc_idx_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  output reg_sel_e          sel_o,
  output logic [OFS_W-1:0]  snap_ofs_o,
  output logic              fault_o,
  output logic              clr_stat_o,
  output logic              clr_addr_o,
  output logic              clr_misc_o
);
  localparam logic [IDX_W:0] SNAP_END = {1'b0, IDX_SNAP_BASE} + (IDX_W+1)'(SNAP_CNT);

  logic [IDX_W-1:0] ofs_full;
  logic             wdata_zero;
  logic             illegal;
  logic             ok_wr;

  assign ofs_full   = acc_idx_i - IDX_SNAP_BASE;
  assign snap_ofs_o = ofs_full[OFS_W-1:0];
  assign wdata_zero = (acc_wdata_i == '0);

  always_comb begin
    sel_o = SEL_NONE;
    if (acc_idx_i == IDX_CAP)                  sel_o = SEL_CAP;
    else if (acc_idx_i == IDX_STAT)            sel_o = SEL_STAT;
    else if (acc_idx_i == IDX_ADDR)            sel_o = SEL_ADDR;
    else if (acc_idx_i == IDX_MISC && MISC_IMPL) sel_o = SEL_MISC;
    else if (acc_idx_i >= IDX_SNAP_BASE && {1'b0, acc_idx_i} < SNAP_END)
                                               sel_o = SEL_SNAP;
  end

  // read-only targets, unmapped indices and nonzero writes all fault
  assign illegal = (sel_o == SEL_NONE)
                 || (acc_wr_i && (sel_o == SEL_CAP || sel_o == SEL_SNAP))
                 || (acc_wr_i && !wdata_zero);
  assign fault_o = acc_vld_i && illegal;
  assign ok_wr   = acc_vld_i && acc_wr_i && !illegal;

  assign clr_stat_o = ok_wr && (sel_o == SEL_STAT);
  assign clr_addr_o = ok_wr && (sel_o == SEL_ADDR);
  assign clr_misc_o = ok_wr && (sel_o == SEL_MISC);
endmodule

// File: rtl/mce_err_core.sv
module mce_err_core #(
  parameter int unsigned DATA_W      = 64,
  parameter int unsigned ADDR_KEEP   = 36,
  parameter bit          NARROW_ADDR = 1'b1,
  parameter bit          MISC_IMPL   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  logic [DATA_W-1:0] stat_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0] misc_i,
  input  logic              clr_stat_i,
  input  logic              clr_addr_i,
  input  logic              clr_misc_i,
  output logic              capture_o,
  output logic [DATA_W-1:0] stat_o,
  output logic [DATA_W-1:0] addr_o,
  output logic [DATA_W-1:0] misc_o
);
  localparam int unsigned VAL_BIT = DATA_W - 1;
  localparam int unsigned OVF_BIT = DATA_W - 2;
  localparam logic [DATA_W-1:0] ADDR_MASK = NARROW_ADDR
      ? {{(DATA_W-ADDR_KEEP){1'b0}}, {ADDR_KEEP{1'b1}}}
      : {DATA_W{1'b1}};

  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:0] addr_q;
  logic              unused_stat_top;

  assign unused_stat_top = ^stat_i[DATA_W-1:DATA_W-2];
  assign capture_o = evt_i && !stat_q[VAL_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         stat_q <= '0;
    else if (capture_o)  stat_q <= {1'b1, 1'b0, stat_i[DATA_W-3:0]};
    else if (evt_i)      stat_q[OVF_BIT] <= 1'b1;
    else if (clr_stat_i) stat_q <= '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         addr_q <= '0;
    else if (capture_o)  addr_q <= addr_i & ADDR_MASK;
    else if (clr_addr_i) addr_q <= '0;
  end

  generate
    if (MISC_IMPL) begin : g_misc
      logic [DATA_W-1:0] misc_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         misc_q <= '0;
        else if (capture_o)  misc_q <= misc_i;
        else if (clr_misc_i) misc_q <= '0;
      end
      assign misc_o = misc_q;
    end else begin : g_no_misc
      logic unused_misc;
      assign unused_misc = ^{misc_i, clr_misc_i};
      assign misc_o = '0;
    end
  endgenerate

  assign stat_o = stat_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/mce_snap_bank.sv
module mce_snap_bank #(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned NUM_SNAP = 4,
  parameter bit          SNAP_EN  = 1'b1,
  parameter int unsigned OFS_W    = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cap_i,
  input  logic [NUM_SNAP*DATA_W-1:0] regs_i,
  input  logic [OFS_W-1:0]           ofs_i,
  output logic [DATA_W-1:0]          rd_o
);
  generate
    if (SNAP_EN) begin : g_snap
      logic [DATA_W-1:0] snap_q [NUM_SNAP];
      for (genvar k = 0; k < NUM_SNAP; k++) begin : g_ent
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)    snap_q[k] <= '0;
          else if (cap_i) snap_q[k] <= regs_i[k*DATA_W +: DATA_W];
        end
      end
      assign rd_o = (int'(ofs_i) < NUM_SNAP) ? snap_q[ofs_i] : '0;
    end else begin : g_no_snap
      logic unused_snap;
      assign unused_snap = ^{clk_i, rst_ni, cap_i, regs_i, ofs_i};
      assign rd_o = '0;
    end
  endgenerate
endmodule

// File: rtl/mce_log_bank.sv
module mce_log_bank
  import mce_log_pkg::*;
#(
  parameter int unsigned DATA_W      = 64,
  parameter int unsigned NUM_SNAP    = 4,
  parameter bit          SNAP_EN     = 1'b1,
  parameter bit          MISC_IMPL   = 1'b1,
  parameter bit          NARROW_ADDR = 1'b1,
  parameter int unsigned ADDR_KEEP   = 36
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       acc_vld_i,
  input  logic                       acc_wr_i,
  input  logic [11:0]                acc_idx_i,
  input  logic [DATA_W-1:0]          acc_wdata_i,
  output logic [DATA_W-1:0]          acc_rdata_o,
  output logic                       fault_o,
  input  logic                       err_evt_i,
  input  logic [DATA_W-1:0]          err_stat_i,
  input  logic [DATA_W-1:0]          err_addr_i,
  input  logic [DATA_W-1:0]          err_misc_i,
  input  logic [NUM_SNAP*DATA_W-1:0] core_regs_i
);
  localparam int unsigned SNAP_CNT = SNAP_EN ? NUM_SNAP : 0;
  localparam int unsigned OFS_W    = (NUM_SNAP > 1) ? $clog2(NUM_SNAP) : 1;
  localparam logic [8:0]  CAP_LO   = {(SNAP_CNT > 0) ? 1'b1 : 1'b0, 8'(SNAP_CNT)};
  localparam logic [DATA_W-1:0] CAP_VAL = {{(DATA_W-9){1'b0}}, CAP_LO};

  reg_sel_e          sel_w;
  logic [OFS_W-1:0]  ofs_w;
  logic              clr_stat_w, clr_addr_w, clr_misc_w;
  logic              capture_w;
  logic [DATA_W-1:0] stat_w, addr_w, misc_w, snap_w;
  logic [DATA_W-1:0] mux_w;

  mce_acc_decode #(
    .DATA_W(DATA_W), .SNAP_CNT(SNAP_CNT), .OFS_W(OFS_W), .MISC_IMPL(MISC_IMPL)
  ) u_dec (
    .acc_vld_i  (acc_vld_i),
    .acc_wr_i   (acc_wr_i),
    .acc_idx_i  (acc_idx_i),
    .acc_wdata_i(acc_wdata_i),
    .sel_o      (sel_w),
    .snap_ofs_o (ofs_w),
    .fault_o    (fault_o),
    .clr_stat_o (clr_stat_w),
    .clr_addr_o (clr_addr_w),
    .clr_misc_o (clr_misc_w)
  );

  mce_err_core #(
    .DATA_W(DATA_W), .ADDR_KEEP(ADDR_KEEP), .NARROW_ADDR(NARROW_ADDR), .MISC_IMPL(MISC_IMPL)
  ) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (err_evt_i),
    .stat_i    (err_stat_i),
    .addr_i    (err_addr_i),
    .misc_i    (err_misc_i),
    .clr_stat_i(clr_stat_w),
    .clr_addr_i(clr_addr_w),
    .clr_misc_i(clr_misc_w),
    .capture_o (capture_w),
    .stat_o    (stat_w),
    .addr_o    (addr_w),
    .misc_o    (misc_w)
  );

  mce_snap_bank #(
    .DATA_W(DATA_W), .NUM_SNAP(NUM_SNAP), .SNAP_EN(SNAP_EN), .OFS_W(OFS_W)
  ) u_snap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap_i (capture_w),
    .regs_i(core_regs_i),
    .ofs_i (ofs_w),
    .rd_o  (snap_w)
  );

  always_comb begin
    unique case (sel_w)
      SEL_CAP:  mux_w = CAP_VAL;
      SEL_STAT: mux_w = stat_w;
      SEL_ADDR: mux_w = addr_w;
      SEL_MISC: mux_w = misc_w;
      SEL_SNAP: mux_w = snap_w;
      default:  mux_w = '0;
    endcase
  end

  assign acc_rdata_o = fault_o ? '0 : mux_w;
endmodule

// File: rtl/mce_log_bank_chk.sv
module mce_log_bank_chk
  import mce_log_pkg::*;
#(
  parameter int unsigned DATA_W      = 64,
  parameter int unsigned ADDR_KEEP   = 36,
  parameter bit          NARROW_ADDR = 1'b1,
  parameter logic [DATA_W-1:0] CAP_VAL = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_vld_i,
  input logic              acc_wr_i,
  input logic [11:0]       acc_idx_i,
  input logic [DATA_W-1:0] acc_wdata_i,
  input logic [DATA_W-1:0] acc_rdata_o,
  input logic              fault_o,
  input logic              err_evt_i,
  input logic [DATA_W-1:0] stat_q,
  input logic [DATA_W-1:0] addr_q
);
  localparam logic [DATA_W-1:0] HI_MASK = NARROW_ADDR
      ? {{(DATA_W-ADDR_KEEP){1'b1}}, {ADDR_KEEP{1'b0}}} : '0;

  AST_FAULT_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> acc_vld_i); // R11

  AST_CAP_READ_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_vld_i && !acc_wr_i && acc_idx_i == IDX_CAP |-> !fault_o && acc_rdata_o == CAP_VAL); // R2

  AST_CAP_WRITE_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_vld_i && acc_wr_i && acc_idx_i == IDX_CAP |-> fault_o); // R10

  AST_SNAP_WRITE_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_vld_i && acc_wr_i && acc_idx_i[11:4] == IDX_SNAP_BASE[11:4] |-> fault_o); // R10

  AST_NZ_WRITE_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_vld_i && acc_wr_i && acc_idx_i == IDX_STAT && acc_wdata_i != '0 && !err_evt_i
    |=> stat_q == $past(stat_q)); // R7

  AST_NZ_WRITE_FAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_vld_i && acc_wr_i && acc_idx_i == IDX_ADDR && acc_wdata_i != '0 |-> fault_o); // R7

  AST_ZERO_WRITE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_vld_i && acc_wr_i && acc_idx_i == IDX_ADDR && acc_wdata_i == '0 && !err_evt_i
    |=> addr_q == '0); // R6

  AST_CAPTURE_SETS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_evt_i && !stat_q[DATA_W-1] |=> stat_q[DATA_W-1] && !stat_q[DATA_W-2]); // R3

  AST_NO_OVERWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_evt_i && stat_q[DATA_W-1] |=> stat_q[DATA_W-2] && $stable(addr_q)); // R4

  AST_ADDR_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_vld_i |-> (addr_q & HI_MASK) == '0); // R5
endmodule

bind mce_log_bank mce_log_bank_chk #(
  .DATA_W(DATA_W), .ADDR_KEEP(ADDR_KEEP), .NARROW_ADDR(NARROW_ADDR), .CAP_VAL(CAP_VAL)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .acc_vld_i  (acc_vld_i),
  .acc_wr_i   (acc_wr_i),
  .acc_idx_i  (acc_idx_i),
  .acc_wdata_i(acc_wdata_i),
  .acc_rdata_o(acc_rdata_o),
  .fault_o    (fault_o),
  .err_evt_i  (err_evt_i),
  .stat_q     (stat_w),
  .addr_q     (addr_w)
);

// File: tb/mce_log_bank_tb_top.sv
module mce_log_bank_tb_top;
  localparam int DW = 64;
  localparam int NS = 4;
  localparam logic [11:0] I_CAP = 12'h179, I_SNAP = 12'h180, I_STAT = 12'h401,
                          I_ADDR = 12'h402, I_MISC = 12'h403;
  localparam logic [63:0] KEEP36 = 64'h0000_000F_FFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_vld = 1'b0, acc_wr = 1'b0;
  logic [11:0] acc_idx = '0;
  logic [DW-1:0] acc_wdata = '0;
  logic err_evt = 1'b0;
  logic [DW-1:0] err_stat = '0, err_addr = '0, err_misc = '0;
  logic [NS*DW-1:0] core_regs = '0;
  logic [DW-1:0] rd, rd2;
  logic fault, fault2;

  logic [DW-1:0] r_rd, r_rd2;
  logic r_f, r_f2;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mce_log_bank #(.DATA_W(DW), .NUM_SNAP(NS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .acc_vld_i(acc_vld), .acc_wr_i(acc_wr),
    .acc_idx_i(acc_idx), .acc_wdata_i(acc_wdata), .acc_rdata_o(rd), .fault_o(fault),
    .err_evt_i(err_evt), .err_stat_i(err_stat), .err_addr_i(err_addr),
    .err_misc_i(err_misc), .core_regs_i(core_regs));

  mce_log_bank #(.DATA_W(DW), .NUM_SNAP(NS), .SNAP_EN(1'b0), .MISC_IMPL(1'b0)) dut_min_i (
    .clk_i(clk), .rst_ni(rst_n), .acc_vld_i(acc_vld), .acc_wr_i(acc_wr),
    .acc_idx_i(acc_idx), .acc_wdata_i(acc_wdata), .acc_rdata_o(rd2), .fault_o(fault2),
    .err_evt_i(err_evt), .err_stat_i(err_stat), .err_addr_i(err_addr),
    .err_misc_i(err_misc), .core_regs_i(core_regs));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [11:0] idx, input logic wr, input logic [DW-1:0] wd);
    @(negedge clk);
    acc_vld = 1'b1; acc_wr = wr; acc_idx = idx; acc_wdata = wd;
    #2;
    r_rd = rd; r_f = fault; r_rd2 = rd2; r_f2 = fault2;
    @(negedge clk);
    acc_vld = 1'b0; acc_wr = 1'b0; acc_wdata = '0;
  endtask

  task automatic pulse_evt(input logic [DW-1:0] st, input logic [DW-1:0] ad,
                           input logic [DW-1:0] mi, input logic [DW-1:0] seed);
    @(negedge clk);
    err_stat = st; err_addr = ad; err_misc = mi;
    for (int k = 0; k < NS; k++) core_regs[k*DW +: DW] = seed * 64'(k + 1);
    err_evt = 1'b1;
    @(negedge clk);
    err_evt = 1'b0;
  endtask

  task automatic t_reset();
    acc(I_STAT, 0, 0); chk("R1 status", r_rd, '0);
    acc(I_ADDR, 0, 0); chk("R1 addr", r_rd, '0);
    acc(I_MISC, 0, 0); chk("R1 misc", r_rd, '0);
    acc(I_SNAP, 0, 0); chk("R1 snap0", r_rd, '0);
    acc(I_CAP, 0, 0);
    chk("R2 cap", r_rd, 64'h104); chk("R2 cap fault", 64'(r_f), 0);
    chk("R2 cap min", r_rd2, 64'h0); chk("R2 cap min fault", 64'(r_f2), 0);
  endtask

  task automatic t_capture();
    logic [DW-1:0] st = 64'hFFFF_0000_1234_5678;
    logic [DW-1:0] ad = 64'hDEAD_BEEF_CAFE_1234;
    pulse_evt(st, ad, 64'h0BAD_F00D_0000_0001, 64'h1111_1111_1111_1111);
    acc(I_STAT, 0, 0);
    chk("R3 status", r_rd, (st & 64'h3FFF_FFFF_FFFF_FFFF) | 64'h8000_0000_0000_0000);
    acc(I_ADDR, 0, 0); chk("R5 addr narrow", r_rd, ad & KEEP36);
    acc(I_MISC, 0, 0); chk("R3 misc", r_rd, 64'h0BAD_F00D_0000_0001);
    for (int k = 0; k < NS; k++) begin
      acc(I_SNAP + 12'(k), 0, 0);
      chk("R9 snap read", r_rd, 64'h1111_1111_1111_1111 * 64'(k + 1));
      chk("R9 snap no fault", 64'(r_f), 0);
    end
    acc(I_SNAP + 12'(NS), 0, 0);
    chk("R9 beyond count fault", 64'(r_f), 1); chk("R11 fault rdata", r_rd, '0);
  endtask

  task automatic t_overflow();
    pulse_evt(64'h0, 64'h1, 64'h2, 64'h3);
    acc(I_STAT, 0, 0); chk("R4 overflow", r_rd, 64'hFFFF_0000_1234_5678);
    acc(I_ADDR, 0, 0); chk("R4 addr kept", r_rd, 64'hDEAD_BEEF_CAFE_1234 & KEEP36);
    acc(I_SNAP + 12'd1, 0, 0); chk("R4 snap kept", r_rd, 64'h2222_2222_2222_2222);
  endtask

  task automatic t_protect();
    acc(I_STAT, 1, 64'h1); chk("R7 nonzero fault", 64'(r_f), 1);
    acc(I_STAT, 0, 0); chk("R7 status kept", r_rd, 64'hFFFF_0000_1234_5678);
    acc(I_MISC, 1, 64'h8000_0000_0000_0000); chk("R7 misc nz fault", 64'(r_f), 1);
    acc(I_MISC, 0, 0); chk("R7 misc kept", r_rd, 64'h0BAD_F00D_0000_0001);
    acc(I_CAP, 1, 0); chk("R10 cap write", 64'(r_f), 1);
    acc(I_CAP, 0, 0); chk("R10 cap kept", r_rd, 64'h104);
    acc(I_SNAP, 1, 0); chk("R10 snap write", 64'(r_f), 1);
    acc(I_SNAP, 0, 0); chk("R10 snap kept", r_rd, 64'h1111_1111_1111_1111);
    acc(12'h000, 0, 0); chk("R11 unmapped fault", 64'(r_f), 1); chk("R11 unmapped rd", r_rd, '0);
    @(negedge clk); acc_idx = 12'h000; #2;
    chk("R11 no strobe no fault", 64'(fault), 0);
  endtask

  task automatic t_clear();
    acc(I_MISC, 1, 0); chk("R6 misc clr no fault", 64'(r_f), 0);
    acc(I_MISC, 0, 0); chk("R6 misc cleared", r_rd, '0);
    acc(I_ADDR, 0, 0); chk("R6 addr untouched", r_rd, 64'hDEAD_BEEF_CAFE_1234 & KEEP36);
    acc(I_STAT, 1, 0); chk("R6 stat clr no fault", 64'(r_f), 0);
    acc(I_STAT, 0, 0); chk("R6 status cleared", r_rd, '0);
    acc(I_ADDR, 1, 0);
    acc(I_ADDR, 0, 0); chk("R6 addr cleared", r_rd, '0);
    pulse_evt(64'h0800_0000_0000_00AA, 64'hFFFF_FFFF_FFFF_FFFF, 64'h55, 64'h0101);
    acc(I_STAT, 0, 0); chk("R3 recapture status", r_rd, 64'h8800_0000_0000_00AA);
    acc(I_ADDR, 0, 0); chk("R5 high bits zero", r_rd, KEEP36);
    acc(I_SNAP + 12'd3, 0, 0); chk("R3 recapture snap", r_rd, 64'h0404);
  endtask

  task automatic t_min_cfg();
    acc(I_MISC, 0, 0); chk("R8 misc read fault", 64'(r_f2), 1); chk("R8 misc read data", r_rd2, '0);
    acc(I_MISC, 1, 0); chk("R8 misc write fault", 64'(r_f2), 1);
    acc(I_SNAP, 0, 0); chk("R9 zero count fault", 64'(r_f2), 1);
    acc(I_STAT, 0, 0); chk("R3 min status", r_rd2, 64'h8800_0000_0000_00AA);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_capture();
    t_overflow();
    t_protect();
    t_clear();
    t_min_cfg();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule